// File: doc/BRIEF.md
# Serial Memory Slave Front-End

This block is the serial-bus slave side of a byte-wide nonvolatile memory of 4096 bytes. It watches chip select, serial clock, serial data in and a pause input. It decodes an 8-bit command, and for array reads it collects a 16-bit address. It then streams memory bytes out on a serial output that has its own drive enable. Array reads go to a memory model through a one-cycle read port. Write-enable, status-write and array-write commands go to neighbouring protection and page-write units as command pulses and forwarded data bytes. A status byte supplied by those units is shifted out on a status read.

The serial pins are asynchronous to the system clock. They are oversampled through two-flop synchronisers, so the block runs on one clock. The serial clock high and low times must each be at least six system clock periods. The bus works in mode 0: input is taken on rising serial-clock edges, and output moves after falling edges. All fields travel most significant bit first. Each transaction starts when chip select falls.

Top module: `spi_mem_front`

## Requirements
- R1: While chip select is high, `so_oe` stays low, and activity on the serial clock and data lines produces no command pulse, no forwarded byte and no memory read.
- R2: The first 8 bits after chip select falls form the opcode. An opcode of the form 0000_x_bbb is accepted for bbb = 110 (set write enable), 100 (clear write enable), 101 (read status), 001 (write status), 011 (read array) and 010 (write array). Bit 3 has no effect. Acceptance gives a one-cycle `cmd_valid` pulse with `cmd_code` equal to bbb.
- R3: An opcode with a nonzero upper nibble, or with bbb equal to 000 or 111, gives no command pulse. All later input in that selection is ignored, with no forwarded byte, no memory read and `so_oe` low, until chip select falls again.
- R4: A read array command takes a 16-bit address whose bits 15:12 are ignored. It issues `mem_rd_en` with address bits 11:0. The most significant bit of that byte appears on `so` after the falling edge that follows the last address bit.
- R5: A read continues byte after byte for as long as clocks arrive. The address rises by one per byte and wraps from 0xFFF to 0x000.
- R6: A read status command shifts out `status_in`, sampled at the start of each byte, and repeats it for every byte clocked.
- R7: After a write status or write array command, every complete later input byte is forwarded once, in order, as a one-cycle `fwd_valid` pulse with `fwd_byte`. A partial byte at deselection is dropped.
- R8: The pause input takes effect only while the serial clock is low. While paused, `so_oe` is low and serial clock edges and input data are ignored. The bit and byte position is kept, so the transfer resumes where it stopped.
- R9: When `busy_in` is high as an opcode completes, every opcode except read status is ignored, as in R3. Read status still works.
- R10: Raising chip select turns `so_oe` off. The next falling edge of chip select restarts opcode capture, even after a lockout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause input, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for `so` |
| cmd_valid | output | 1 | One-cycle pulse for an accepted opcode |
| cmd_code | output | 3 | Low three opcode bits of the accepted command |
| fwd_valid | output | 1 | One-cycle pulse for a forwarded byte |
| fwd_byte | output | 8 | Forwarded data byte |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the request |
| status_in | input | 8 | Status byte from the protection unit |
| busy_in | input | 1 | Internal write cycle in progress |

## Verification
The bench sweeps all 256 opcode values, each followed by a filler byte. This separates accepted from rejected codes, confirms that bit 3 is ignored, and shows which codes drive the output or forward the filler. Array reads are run at a plain address, at an address with the upper nibble set and across the 0xFFF boundary, to tell address truncation from wrap. Further runs cover a lockout followed by a deselect and reselect, a pause in mid-byte with clock and data toggling, a busy window, and a write stream that ends in a partial byte. Together these show that position is kept, that commands are ignored while busy, and that partial bytes are dropped.

// File: rtl/spi_mem_front.sv
module spi_mem_front #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  output logic              so,
  output logic              so_oe,
  output logic              cmd_valid,
  output logic [2:0]        cmd_code,
  output logic              fwd_valid,
  output logic [7:0]        fwd_byte,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  input  logic [7:0]        status_in,
  input  logic              busy_in
);

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_ADDR, S_DOUT, S_STAT, S_FWD, S_LOCK} st_t;

  logic cs_m, cs_s, cs_q, sck_m, sck_s, sck_q, si_m, si_s, hold_m, hold_s;
  logic hold_act;
  st_t  st;
  logic [15:0] rx_sh;
  logic [3:0]  rx_cnt;
  logic [7:0]  tx_sh, nbuf;
  logic [2:0]  tx_cnt;
  logic        so_r, so_on, rd_req, rd_dly;
  logic [ADDR_W-1:0] addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {cs_m, cs_s, cs_q} <= 3'b111;
      {sck_m, sck_s, sck_q, si_m, si_s} <= '0;
      {hold_m, hold_s} <= 2'b11;
      hold_act <= 1'b0;
    end else begin
      cs_m <= cs_n;    cs_s <= cs_m;    cs_q <= cs_s;
      sck_m <= sck;    sck_s <= sck_m;  sck_q <= sck_s;
      si_m <= si;      si_s <= si_m;
      hold_m <= hold_n; hold_s <= hold_m;
      if (!sck_s) hold_act <= ~hold_s;
    end

  wire cs_fall  = cs_q & ~cs_s;
  wire sck_rise = sck_s & ~sck_q & ~hold_act & ~cs_s;
  wire sck_fall = ~sck_s & sck_q & ~hold_act & ~cs_s;

  wire [7:0]  rx_byte = {rx_sh[6:0], si_s};
  wire [15:0] rx_word = {rx_sh[14:0], si_s};
  wire op_ok   = (rx_byte[7:4] == 4'h0) && (rx_byte[2:0] != 3'b000) && (rx_byte[2:0] != 3'b111);
  wire op_take = op_ok && (!busy_in || rx_byte[2:0] == 3'b101);
  wire [7:0] src = (st == S_STAT) ? status_in : nbuf;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      rx_sh <= '0; rx_cnt <= '0; tx_sh <= '0; tx_cnt <= '0; nbuf <= '0;
      so_r <= 1'b0; so_on <= 1'b0; rd_req <= 1'b0; rd_dly <= 1'b0;
      addr <= '0; cmd_valid <= 1'b0; cmd_code <= '0; fwd_valid <= 1'b0; fwd_byte <= '0;
    end else begin
      cmd_valid <= 1'b0;
      fwd_valid <= 1'b0;
      rd_req    <= 1'b0;
      rd_dly    <= rd_req;
      if (rd_dly) begin
        nbuf <= mem_rd_data;
        addr <= addr + 1'b1;
      end
      if (cs_s) begin
        st    <= S_IDLE;
        so_on <= 1'b0;
      end else if (cs_fall) begin
        st     <= S_OPC;
        rx_cnt <= '0;
        tx_cnt <= '0;
        so_on  <= 1'b0;
      end else begin
        if (sck_rise) begin
          rx_sh <= rx_word;
          case (st)
            S_OPC:
              if (rx_cnt == 4'd7) begin
                rx_cnt <= '0;
                if (op_take) begin
                  cmd_valid <= 1'b1;
                  cmd_code  <= rx_byte[2:0];
                  case (rx_byte[2:0])
                    3'b011:         st <= S_ADDR;
                    3'b101:         st <= S_STAT;
                    3'b001, 3'b010: st <= S_FWD;
                    default:        st <= S_LOCK;
                  endcase
                end else st <= S_LOCK;
              end else rx_cnt <= rx_cnt + 1'b1;
            S_ADDR:
              if (rx_cnt == 4'd15) begin
                rx_cnt <= '0;
                addr   <= rx_word[ADDR_W-1:0];
                rd_req <= 1'b1;
                st     <= S_DOUT;
              end else rx_cnt <= rx_cnt + 1'b1;
            S_FWD:
              if (rx_cnt == 4'd7) begin
                rx_cnt    <= '0;
                fwd_valid <= 1'b1;
                fwd_byte  <= rx_byte;
              end else rx_cnt <= rx_cnt + 1'b1;
            default: ;
          endcase
        end
        if (sck_fall && (st == S_DOUT || st == S_STAT)) begin
          so_on <= 1'b1;
          if (tx_cnt == 3'd0) begin
            so_r   <= src[7];
            tx_sh  <= {src[6:0], 1'b0};
            tx_cnt <= 3'd7;
            if (st == S_DOUT) rd_req <= 1'b1;
          end else begin
            so_r   <= tx_sh[7];
            tx_sh  <= {tx_sh[6:0], 1'b0};
            tx_cnt <= tx_cnt - 1'b1;
          end
        end
      end
    end

  assign so          = so_r;
  assign so_oe       = so_on & ~hold_act & ~cs_s;
  assign mem_rd_en   = rd_req;
  assign mem_rd_addr = addr;

endmodule

// File: rtl/spi_mem_front_chk.sv
module spi_mem_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       so_oe,
  input logic       cmd_valid,
  input logic [2:0] cmd_code,
  input logic       fwd_valid,
  input logic       mem_rd_en,
  input logic       busy_in,
  input logic       hold_act,
  input logic       cs_s,
  input logic       cs_q,
  input logic [3:0] rx_cnt,
  input logic [2:0] st
);
  a_r10_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !so_oe);
  a_r2_cmd_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  a_r4_read_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
  a_r3_lock_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd6) |-> (!so_oe && !fwd_valid && !mem_rd_en));
  a_r8_hold_freezes_position: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_act && !cs_s && !cs_q) |=> $stable(rx_cnt));
  a_r9_busy_status_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && $past(busy_in)) |-> (cmd_code == 3'b101));
  a_r7_fwd_from_write_state: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> ($past(st) == 3'd5));
endmodule

bind spi_mem_front spi_mem_front_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so_oe(so_oe), .cmd_valid(cmd_valid),
  .cmd_code(cmd_code), .fwd_valid(fwd_valid), .mem_rd_en(mem_rd_en), .busy_in(busy_in),
  .hold_act(hold_act), .cs_s(cs_s), .cs_q(cs_q), .rx_cnt(rx_cnt), .st(st)
);

// File: tb/spi_mem_front_tb_top.sv
module spi_mem_front_tb_top;
  localparam int HP = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, busy_in = 1'b0;
  logic [7:0] status_in = 8'h00, mem_rd_data = 8'h00;
  logic so, so_oe, cmd_valid, fwd_valid, mem_rd_en;
  logic [2:0] cmd_code;
  logic [7:0] fwd_byte;
  logic [11:0] mem_rd_addr;

  int vectors = 0, miscompares = 0;
  int n_cmd = 0, n_fwd = 0, n_rd = 0, oe_cnt = 0;
  logic [2:0] last_code = '0;
  logic [7:0] fwd_log [0:7];

  always #10 clk = ~clk;

  spi_mem_front #(.ADDR_W(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .fwd_valid(fwd_valid), .fwd_byte(fwd_byte), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .status_in(status_in), .busy_in(busy_in));

  function automatic logic [7:0] fref(input int a);
    return 8'((a * 37) + (a >> 8) + 5);
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= fref(int'(mem_rd_addr));

  always @(posedge clk) begin
    if (cmd_valid) begin n_cmd++; last_code = cmd_code; end
    if (fwd_valid) begin if (n_fwd < 8) fwd_log[n_fwd] = fwd_byte; n_fwd++; end
    if (mem_rd_en) n_rd++;
  end
  always @(negedge clk) if (so_oe) oe_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    n_cmd = 0; n_fwd = 0; n_rd = 0; oe_cnt = 0;
  endtask

  task automatic sel();
    cs_n = 1'b0; repeat (HP) @(negedge clk);
  endtask
  task automatic desel();
    repeat (HP) @(negedge clk); cs_n = 1'b1; repeat (2 * HP) @(negedge clk);
  endtask

  task automatic sbit(input logic b, output logic r);
    si = b;
    repeat (HP) @(negedge clk);
    r = so;
    sck = 1'b1;
    repeat (HP) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      sbit(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic xbyte_hold(input logic [7:0] tx, input int at, output logic [7:0] rx, output int oe_h);
    oe_h = 0;
    for (int i = 7; i >= 0; i--) begin
      logic r;
      if (i == at) begin
        hold_n = 1'b0;
        repeat (HP) @(negedge clk);
        oe_h += int'(so_oe);
        for (int k = 0; k < 3; k++) begin
          si = ~si; sck = 1'b1; repeat (HP) @(negedge clk);
          oe_h += int'(so_oe);
          sck = 1'b0; repeat (HP) @(negedge clk);
          oe_h += int'(so_oe);
        end
        hold_n = 1'b1;
        repeat (HP) @(negedge clk);
      end
      sbit(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic rd_run(input logic [15:0] a, input int nb, input string tag);
    logic [7:0] d;
    sel();
    xbyte(8'h03, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
    for (int k = 0; k < nb; k++) begin
      xbyte(8'h00, d);
      chk(tag, int'(d), int'(fref((int'(a) + k) & 12'hFFF)));
    end
    desel();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int oe_h;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 reset so_oe", int'(so_oe), 0);
    chk("R1 reset cmd_valid", int'(cmd_valid), 0);

    // R1: clocks and data while deselected
    clr();
    for (int i = 7; i >= 0; i--) begin logic r; sbit(1'(8'h03 >> i), r); end
    for (int i = 7; i >= 0; i--) begin logic r; sbit(1'(8'h02 >> i), r); end
    chk("R1 deselected cmd", n_cmd, 0);
    chk("R1 deselected oe", oe_cnt, 0);
    chk("R1 deselected rd", n_rd, 0);

    // R2 / R3 / R6 / R7: exhaustive opcode sweep
    status_in = 8'h5A;
    for (int op = 0; op < 256; op++) begin
      logic ok;
      logic [2:0] lo;
      lo = 3'(op);
      ok = (op[7:4] == 4'h0) && (lo != 3'b000) && (lo != 3'b111);
      clr();
      sel(); xbyte(8'(op), d); xbyte(8'hA5, d); desel();
      chk(ok ? "R2 accept count" : "R3 reject count", n_cmd, int'(ok));
      if (ok) chk("R2 cmd_code bit3 ignored", int'(last_code), int'(lo));
      chk(ok ? "R2 output drive" : "R3 lockout drive", int'(oe_cnt > 0), int'(ok && lo == 3'b101));
      if (ok && lo == 3'b101) chk("R6 status byte", int'(d), 8'h5A);
      chk(ok ? "R7 forward count" : "R3 lockout forward", n_fwd, int'(ok && (lo == 3'b001 || lo == 3'b010)));
      if (ok && (lo == 3'b001 || lo == 3'b010)) chk("R7 forward byte", int'(fwd_log[0]), 8'hA5);
    end

    // R4 / R5: reads
    clr();
    rd_run(16'h0123, 3, "R4 R5 read 0x123");
    chk("R4 read request issued", int'(n_rd > 0), 1);
    rd_run(16'hF123, 2, "R4 upper address bits ignored");
    rd_run(16'h0FFE, 4, "R5 wrap at 0xFFF");

    // R6: status repeats, sampled each byte
    status_in = 8'h8C;
    sel(); xbyte(8'h05, d);
    xbyte(8'h00, d); chk("R6 status first", int'(d), 8'h8C);
    xbyte(8'h00, d); chk("R6 status repeat", int'(d), 8'h8C);
    desel();

    // R3 / R10: lockout then restart
    clr();
    sel(); xbyte(8'hFF, d); xbyte(8'h03, d); xbyte(8'h00, d); xbyte(8'h10, d); xbyte(8'h00, d); desel();
    chk("R3 lockout no cmd", n_cmd, 0);
    chk("R3 lockout no read", n_rd, 0);
    chk("R3 lockout no drive", oe_cnt, 0);
    status_in = 8'h31;
    sel(); xbyte(8'h05, d); xbyte(8'h00, d); desel();
    chk("R10 restart after lockout", int'(d), 8'h31);
    chk("R10 oe off after deselect", int'(so_oe), 0);

    // R7: write stream with trailing partial byte
    clr();
    sel(); xbyte(8'h02, d); xbyte(8'h01, d); xbyte(8'h23, d); xbyte(8'h55, d); xbyte(8'hAA, d);
    for (int i = 0; i < 3; i++) begin logic r; sbit(1'b1, r); end
    desel();
    chk("R7 forward count partial dropped", n_fwd, 4);
    chk("R7 forward order 0", int'(fwd_log[0]), 8'h01);
    chk("R7 forward order 1", int'(fwd_log[1]), 8'h23);
    chk("R7 forward order 2", int'(fwd_log[2]), 8'h55);
    chk("R7 forward order 3", int'(fwd_log[3]), 8'hAA);

    // R8: pause in mid-byte during a read
    sel(); xbyte(8'h03, d); xbyte(8'h04, d); xbyte(8'h56, d);
    xbyte_hold(8'h00, 3, d, oe_h);
    chk("R8 byte across pause", int'(d), int'(fref(12'h456)));
    chk("R8 output off while paused", oe_h, 0);
    xbyte(8'h00, d);
    chk("R8 next byte after pause", int'(d), int'(fref(12'h457)));
    desel();

    // R9: busy window
    busy_in = 1'b1; status_in = 8'hFF;
    clr();
    sel(); xbyte(8'h06, d); desel();
    chk("R9 busy ignores set-enable", n_cmd, 0);
    sel(); xbyte(8'h03, d); xbyte(8'h00, d); xbyte(8'h00, d); xbyte(8'h00, d); desel();
    chk("R9 busy ignores read", n_rd, 0);
    chk("R9 busy read no drive", oe_cnt, 0);
    sel(); xbyte(8'h0D, d); xbyte(8'h00, d); desel();
    chk("R9 busy status allowed", n_cmd, 1);
    chk("R9 busy status byte", int'(d), 8'hFF);
    busy_in = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule